// File: doc/BRIEF.md
# Integer-N Synthesizer Divider and Phase/Frequency Comparator

This block is the digital heart of an integer-N frequency synthesizer. The VCO is first divided by a fixed external divide-by-8 prescaler that cannot be bypassed. A 15-bit programmable counter then divides the prescaler output again. A second counter divides the crystal oscillator, by either 512 or 1024. A three-state phase/frequency comparator looks at the two divided streams. It drives an "up" request and a "down" request into an external charge pump, and it carries a pump-current select (high or low). A lock detector watches how closely the two edges line up. Either divided stream can be routed to a single test tap.

The whole core runs on one clock. The prescaler output and the oscillator each appear as a one-cycle enable strobe (`presc_en`, `xtal_en`), and each divider advances only on its own strobe. The asynchronous active-low reset is released through a two-stage synchronizer. So the internal state leaves reset on the second rising edge after `rst_n` goes high.

Top module: `pll_core`

## Requirements
- R1: While reset is applied, and until the synchronizer releases it, `pump_up`, `pump_dn`, `cp_hi`, `locked` and `tap_out` are all 0.
- R2: The feedback divider emits one internal pulse per `max(n_ratio,2)` cycles in which `presc_en` is 1. After reset the first pulse follows the first enabled cycle. The pulse is visible on `tap_out` two rising edges after that enabled cycle.
- R3: An `n_ratio` of 0 or 1 divides by 2: with `presc_en` held at 1, the divided stream pulses every second cycle.
- R4: A new `n_ratio` is loaded only at terminal count, so the period already running completes with the old ratio.
- R5: The reference divider emits one pulse per 512 `xtal_en` cycles when `ref_sel` is 0, and one per 1024 when it is 1. A change of `ref_sel` is applied at the next reload.
- R6: `pump_up` goes to 1 on the edge after an internal reference pulse, and `pump_dn` on the edge after an internal feedback pulse. Each stays at 1 until both are 1.
- R7: When `pump_up` and `pump_dn` are both 1, both are 0 on the next edge. They are never both 1 on two cycles in a row.
- R8: `cp_hi` equals the value `cp_hi_sel` had one cycle earlier (1 = high pump current, 0 = low).
- R9: A comparison is good when at most one `xtal_en` cycle passes while exactly one pump output is 1. `locked` rises on the edge after the 8th good comparison in a row.
- R10: The first comparison that is not good clears `locked` on the following edge and restarts the count of good comparisons.
- R11: `tap_out` is the OR of the reference pulse gated by `tap_ref_en` and the feedback pulse gated by `tap_vco_en`. Each pulse appears one cycle after it is generated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_en | input | 1 | One-cycle strobe per prescaler output period |
| xtal_en | input | 1 | One-cycle strobe per oscillator period |
| n_ratio | input | 15 | Feedback division ratio |
| ref_sel | input | 1 | Reference ratio: 0 = 512, 1 = 1024 |
| cp_hi_sel | input | 1 | Pump current request: 1 = high |
| tap_ref_en | input | 1 | Route the divided reference to the tap |
| tap_vco_en | input | 1 | Route the divided feedback to the tap |
| pump_up | output | 1 | Charge pump source request |
| pump_dn | output | 1 | Charge pump sink request |
| cp_hi | output | 1 | Registered pump current select |
| locked | output | 1 | Phase lock flag |
| tap_out | output | 1 | Test tap of the selected divided pulses |

## Verification
The comparator and lock flag are tried with three input patterns:
- Both strobes held at 1 with a feedback ratio equal to the reference ratio. The edges coincide, so lock must appear after exactly eight comparisons and not after six.
- A detuned ratio of 600. This separates a detector that tolerates one tick of skew from one that ignores skew altogether.
- Long runs of sparse random strobes with small random ratios. These exercise reordering of up and down events and pulses lost in the overlap cycle, against a cycle model.

Directed tap counts check the ratios themselves. The minimum-ratio clamp shows as 20 pulses in 40 cycles. The two reference settings give 2 or 4 pulses in 2048 cycles, which no off-by-one divider matches. A gap measurement of 2 then 5 separates a ratio change taken at reload from one taken at once.

// File: rtl/pll_pkg.sv
package pll_pkg;
  localparam int NDIV_W_DEF   = 15;
  localparam int REF_LO_DEF   = 512;
  localparam int REF_HI_DEF   = 1024;
  localparam int LOCK_N_DEF   = 8;
  localparam int LOCK_TOL_DEF = 1;
  localparam int MIN_RATIO    = 2;
endpackage

// File: rtl/pll_rst_sync.sv
module pll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pll_cnt_div.sv
module pll_cnt_div #(
  parameter int W         = 15,
  parameter int MIN_RATIO = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt_q, cnt_d, eff;
  logic         pulse_d;

  // ratio floor, then count down; reload happens only at terminal count
  always_comb begin
    eff     = (ratio < W'(MIN_RATIO)) ? W'(MIN_RATIO) : ratio;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (en) begin
      if (cnt_q == '0) begin
        pulse_d = 1'b1;
        cnt_d   = eff - W'(1);
      end else begin
        cnt_d   = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_p,
  input  logic fb_p,
  output logic up,
  output logic dn
);
  logic up_d, dn_d;

  // three states: idle, up only, down only; both set means clear
  always_comb begin
    if (up && dn) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up | ref_p;
      dn_d = dn | fb_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_d;
      dn <= dn_d;
    end
  end
endmodule

// File: rtl/pll_lock.sv
module pll_lock #(
  parameter int LOCK_N   = 8,
  parameter int LOCK_TOL = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  input  logic tick,
  output logic locked
);
  localparam int GW = (LOCK_N > 1) ? $clog2(LOCK_N) : 1;
  localparam int EW = $clog2(LOCK_TOL + 2);
  localparam logic [EW-1:0] ERR_SAT = EW'(LOCK_TOL + 1);
  localparam logic [GW-1:0] GOOD_TOP = GW'(LOCK_N - 1);

  logic [EW-1:0] err_q, err_d;
  logic [GW-1:0] good_q, good_d;
  logic          lock_d;

  always_comb begin
    err_d  = err_q;
    good_d = good_q;
    lock_d = locked;
    if (up && dn) begin
      err_d = '0;
      if (err_q <= EW'(LOCK_TOL)) begin
        if (good_q == GOOD_TOP) lock_d = 1'b1;
        else                    good_d = good_q + GW'(1);
      end else begin
        good_d = '0;
        lock_d = 1'b0;
      end
    end else if ((up ^ dn) && tick && (err_q != ERR_SAT)) begin
      err_d = err_q + EW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
      locked <= 1'b0;
    end else begin
      err_q  <= err_d;
      good_q <= good_d;
      locked <= lock_d;
    end
  end
endmodule

// File: rtl/pll_core.sv
module pll_core
  import pll_pkg::*;
#(
  parameter int N_W      = NDIV_W_DEF,
  parameter int REF_LO   = REF_LO_DEF,
  parameter int REF_HI   = REF_HI_DEF,
  parameter int LOCK_N   = LOCK_N_DEF,
  parameter int LOCK_TOL = LOCK_TOL_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           presc_en,
  input  logic           xtal_en,
  input  logic [N_W-1:0] n_ratio,
  input  logic           ref_sel,
  input  logic           cp_hi_sel,
  input  logic           tap_ref_en,
  input  logic           tap_vco_en,
  output logic           pump_up,
  output logic           pump_dn,
  output logic           cp_hi,
  output logic           locked,
  output logic           tap_out
);
  localparam int RW = $clog2(REF_HI) + 1;

  logic          rst_sync_n;
  logic          vco_pulse, ref_pulse;
  logic [RW-1:0] ref_ratio;
  logic          cp_hi_d, tap_d;

  pll_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pll_cnt_div #(.W(N_W), .MIN_RATIO(MIN_RATIO)) i_ndiv (
    .clk(clk), .rst_n(rst_sync_n), .en(presc_en), .ratio(n_ratio), .pulse(vco_pulse)
  );

  assign ref_ratio = ref_sel ? RW'(REF_HI) : RW'(REF_LO);

  pll_cnt_div #(.W(RW), .MIN_RATIO(MIN_RATIO)) i_rdiv (
    .clk(clk), .rst_n(rst_sync_n), .en(xtal_en), .ratio(ref_ratio), .pulse(ref_pulse)
  );

  pll_pfd i_pfd (
    .clk(clk), .rst_n(rst_sync_n), .ref_p(ref_pulse), .fb_p(vco_pulse),
    .up(pump_up), .dn(pump_dn)
  );

  pll_lock #(.LOCK_N(LOCK_N), .LOCK_TOL(LOCK_TOL)) i_lock (
    .clk(clk), .rst_n(rst_sync_n), .up(pump_up), .dn(pump_dn),
    .tick(xtal_en), .locked(locked)
  );

  always_comb begin
    cp_hi_d = cp_hi_sel;
    tap_d   = (tap_ref_en & ref_pulse) | (tap_vco_en & vco_pulse);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cp_hi   <= 1'b0;
      tap_out <= 1'b0;
    end else begin
      cp_hi   <= cp_hi_d;
      tap_out <= tap_d;
    end
  end
endmodule

// File: rtl/pll_core_chk.sv
module pll_core_chk (
  input logic clk,
  input logic rst_sync_n,
  input logic presc_en,
  input logic xtal_en,
  input logic vco_pulse,
  input logic ref_pulse,
  input logic pump_up,
  input logic pump_dn,
  input logic cp_hi_sel,
  input logic cp_hi,
  input logic locked
);
  AST_FB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vco_pulse |-> $past(presc_en)); // R2
  AST_FB_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vco_pulse |=> !vco_pulse); // R3
  AST_REF_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ref_pulse |-> $past(xtal_en)); // R5
  AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pump_up) |-> $past(ref_pulse)); // R6
  AST_DN_FROM_FB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(pump_dn) |-> $past(vco_pulse)); // R6
  AST_OVERLAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pump_up && pump_dn) |=> (!pump_up && !pump_dn)); // R7
  AST_CPHI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (cp_hi == $past(cp_hi_sel))); // R8
  AST_LOCK_RISE_AT_CMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(locked) |-> $past(pump_up && pump_dn)); // R9
  AST_LOCK_FALL_AT_CMP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(locked) |-> $past(pump_up && pump_dn)); // R10
endmodule

bind pll_core pll_core_chk i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .presc_en(presc_en), .xtal_en(xtal_en),
  .vco_pulse(vco_pulse), .ref_pulse(ref_pulse), .pump_up(pump_up),
  .pump_dn(pump_dn), .cp_hi_sel(cp_hi_sel), .cp_hi(cp_hi), .locked(locked)
);

// File: tb/test_pll_core.sv
module test_pll_core;
  logic        clk = 1'b0;
  logic        rst_n, presc_en, xtal_en, ref_sel, cp_hi_sel, tap_ref_en, tap_vco_en;
  logic [14:0] n_ratio;
  logic        pump_up, pump_dn, cp_hi, locked, tap_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  bit m_s1, m_s2, m_vp, m_rp, m_up, m_dn, m_lk, m_cp, m_tap;
  int m_nc, m_rc, m_err, m_good;

  always #10 clk = ~clk;

  pll_core i_pll_core (
    .clk(clk), .rst_n(rst_n), .presc_en(presc_en), .xtal_en(xtal_en),
    .n_ratio(n_ratio), .ref_sel(ref_sel), .cp_hi_sel(cp_hi_sel),
    .tap_ref_en(tap_ref_en), .tap_vco_en(tap_vco_en), .pump_up(pump_up),
    .pump_dn(pump_dn), .cp_hi(cp_hi), .locked(locked), .tap_out(tap_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_n(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic model_clear();
    m_vp = 0; m_rp = 0; m_up = 0; m_dn = 0; m_lk = 0; m_cp = 0; m_tap = 0;
    m_nc = 0; m_rc = 0; m_err = 0; m_good = 0;
  endtask

  // advance the model by one rising edge using the inputs held across it
  task automatic model_step();
    bit nvp, nrp, nup, ndn, nlk;
    int nnc, nrc, nerr, ngood;
    if (!rst_n) begin
      model_clear(); m_s1 = 0; m_s2 = 0;
      return;
    end
    if (!m_s2) model_clear();
    else begin
      nvp = 0; nnc = m_nc;
      if (presc_en) begin
        if (m_nc == 0) begin nvp = 1; nnc = eff_n(int'(n_ratio)) - 1; end
        else nnc = m_nc - 1;
      end
      nrp = 0; nrc = m_rc;
      if (xtal_en) begin
        if (m_rc == 0) begin nrp = 1; nrc = (ref_sel ? 1024 : 512) - 1; end
        else nrc = m_rc - 1;
      end
      if (m_up && m_dn) begin nup = 0; ndn = 0; end
      else begin nup = m_up | m_rp; ndn = m_dn | m_vp; end
      nerr = m_err; ngood = m_good; nlk = m_lk;
      if (m_up && m_dn) begin
        nerr = 0;
        if (m_err <= 1) begin
          if (m_good == 7) nlk = 1; else ngood = m_good + 1;
        end else begin ngood = 0; nlk = 0; end
      end else if ((m_up ^ m_dn) && xtal_en && m_err < 2) nerr = m_err + 1;
      m_tap = (tap_ref_en & m_rp) | (tap_vco_en & m_vp);
      m_cp  = cp_hi_sel;
      m_vp = nvp; m_nc = nnc; m_rp = nrp; m_rc = nrc;
      m_up = nup; m_dn = ndn; m_err = nerr; m_good = ngood; m_lk = nlk;
    end
    m_s2 = m_s1; m_s1 = 1;
  endtask

  task automatic cyc();
    @(negedge clk);
    model_step();
    chk("R6 R7 pump_up", int'(pump_up), int'(m_up));
    chk("R6 R7 pump_dn", int'(pump_dn), int'(m_dn));
    chk("R8 cp_hi", int'(cp_hi), int'(m_cp));
    chk("R9 R10 locked", int'(locked), int'(m_lk));
    chk("R2 R11 tap_out", int'(tap_out), int'(m_tap));
  endtask

  task automatic run(input int k);
    for (int i = 0; i < k; i++) cyc();
  endtask

  task automatic count_taps(input int k, output int cnt);
    cnt = 0;
    for (int i = 0; i < k; i++) begin cyc(); cnt += int'(tap_out); end
  endtask

  task automatic gap_to_tap(output int g);
    g = 0;
    do begin cyc(); g++; end while (!tap_out && g < 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c, g;
    void'($urandom(32'h1c3a_77e1));
    rst_n = 0; presc_en = 0; xtal_en = 0; n_ratio = 15'd512; ref_sel = 0;
    cp_hi_sel = 1; tap_ref_en = 1; tap_vco_en = 1;
    run(4);
    // R1: everything quiet in reset
    chk("R1 reset pump_up", int'(pump_up), 0);
    chk("R1 reset pump_dn", int'(pump_dn), 0);
    chk("R1 reset cp_hi", int'(cp_hi), 0);
    chk("R1 reset locked", int'(locked), 0);
    chk("R1 reset tap_out", int'(tap_out), 0);
    rst_n = 1; presc_en = 1; xtal_en = 1;
    cyc();
    chk("R1 sync hold cp_hi", int'(cp_hi), 0);

    // coincident edges: lock after 8 comparisons, not after 6
    run(2999);
    chk("R9 not yet locked", int'(locked), 0);
    run(2000);
    chk("R9 locked after 8", int'(locked), 1);

    // detuned ratio drops lock
    n_ratio = 15'd600;
    run(3000);
    chk("R10 lock lost", int'(locked), 0);

    // minimum ratio clamp
    n_ratio = 15'd1; tap_ref_en = 0; tap_vco_en = 1;
    run(700);
    count_taps(40, c);
    chk("R3 ratio 1 as 2", c, 20);
    n_ratio = 15'd0;
    run(4);
    count_taps(40, c);
    chk("R3 ratio 0 as 2", c, 20);

    // ratio change waits for reload
    n_ratio = 15'd1;
    gap_to_tap(g);
    n_ratio = 15'd5;
    gap_to_tap(g);
    chk("R4 running period kept", g, 2);
    gap_to_tap(g);
    chk("R4 new ratio applied", g, 5);

    // reference ratios through the tap
    tap_vco_en = 0; tap_ref_en = 1; ref_sel = 1;
    run(1100);
    count_taps(2048, c);
    chk("R5 ref 1024", c, 2);
    ref_sel = 0;
    run(1100);
    count_taps(2048, c);
    chk("R5 ref 512", c, 4);

    // pump current select
    cp_hi_sel = 1; cyc();
    chk("R8 cp_hi high", int'(cp_hi), 1);
    cp_hi_sel = 0; cyc();
    chk("R8 cp_hi low", int'(cp_hi), 0);

    // random mix against the model
    for (int i = 0; i < 60000; i++) begin
      presc_en = ($urandom % 4) != 0;
      xtal_en  = ($urandom % 3) != 0;
      if ($urandom % 500 == 0) n_ratio = 15'($urandom % 40);
      if ($urandom % 4000 == 0) ref_sel = ~ref_sel;
      if ($urandom % 16 == 0) cp_hi_sel = $urandom % 2;
      if ($urandom % 300 == 0) begin tap_ref_en = $urandom % 2; tap_vco_en = $urandom % 2; end
      cyc();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule